// File: doc/BRIEF.md
# Vector branch condition evaluator

This unit reduces a vector of condition-register field tests to a single branch decision. After a start pulse it latches the vector length, the predicate mask, the flat array of 4-bit condition fields, the branch-option bits, the bit selector and the mode bits. It then walks the elements in order, one element per clock, and stops at the first element that settles the outcome. While it walks, it keeps a running count register up to date, can shorten the vector length at the exit point, and at the end reports whether the branch is taken and whether the link register is to be written.

The control is a three-state machine. `S_IDLE` waits for `start`. It takes the transition *launch* to `S_STEP`, or the transition *empty* straight to `S_DONE` when the length is zero. `S_STEP` tests one element per cycle. It stays in that state on *advance* and leaves on *finish* when the last element, an early exit, a truncation or a scalar stop occurs. `S_DONE` raises `done` for one cycle and takes the transition *retire* back to `S_IDLE`. The results stay on the outputs until the next launch.

Top module: `vbc_eval`

## Requirements
- R1: After reset `done`, `taken`, `lr_we` and `vl_changed` are low, and `ctr_out` and `vl_out` are zero.
- R2: An element's condition holds when `bo[0]` is 1 or when the tested bit equals `bo[1]`. Its counter check holds when `bo[2]` is 1 or when (count nonzero) XOR `bo[3]` is true. The count used is the value before that element's own decrement. The element passes when both hold.
- R3: The tested bit is bit `bi[1:0]` of a field, where field f occupies `cr_fields[4f+3:4f]`. Element k reads field (`bi[5:2]` + k) mod 16.
- R4: With `all_mode`=1, `taken` is the AND of the results of all tested elements, and the walk stops after the first element that fails. With `all_mode`=0 it is the OR of those results, and the walk stops after the first element that passes.
- R5: With `vl_in`=0, no element is tested, `taken` equals `all_mode`, the count is unchanged, and `done` rises one cycle after the launch.
- R6: A masked-out element (mask bit 0) with `sz`=1 is tested with `snz` in place of the field bit.
- R7: A masked-out element with `sz`=0 has no effect on the result, the truncation or the stop. The one exception is that the count decrements by one when `bo[2]`=0, `ctr_test`=1 and `cti`=0.
- R8: For a tested element the count decrements by one, wrapping modulo 2^16, when `bo[2]`=0. It does not decrement when `ctr_test`=1 and (condition XOR `cti`) is 1.
- R9: With `vlset`=1, the first tested element whose pass result equals `vsb` stops the walk and sets `vl_changed`. `vl_out` becomes index+1 when `vli`=1. Otherwise it becomes index+1 of the most recent tested element before it, or 0 if there is none. Without truncation, `vl_out` equals `vl_in` and `vl_changed` is 0.
- R10: With `bi_scalar`=1, every element reads field `bi[5:2]` and the walk stops after the first tested element.
- R11: `lr_we` equals `lk` XOR (`lru` AND `taken`), qualified by `done`. `lr_val` is `cia`+8.
- R12: One element is processed per cycle, skipped elements included. `done` rises in the cycle after the last element processed and lasts one cycle. A `start` that arrives while the unit is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, accepted only when idle |
| vl_in | input | 4 | Vector length, 0..8 |
| pmask | input | 8 | Predicate mask, bit k for element k |
| cr_fields | input | 64 | Sixteen 4-bit condition fields |
| bo | input | 4 | Branch-option bits |
| bi | input | 6 | Field index [5:2] and bit selector [1:0] |
| all_mode | input | 1 | AND reduction when 1, OR reduction when 0 |
| snz | input | 1 | Substitute bit for masked elements when sz=1 |
| sz | input | 1 | Masked elements tested (1) or skipped (0) |
| ctr_test | input | 1 | Count decrement depends on the test |
| cti | input | 1 | Inverts the count-test rule |
| vlset | input | 1 | Enables length truncation |
| vsb | input | 1 | Pass value that triggers truncation |
| vli | input | 1 | Truncation includes the current element |
| lk | input | 1 | Link write request |
| lru | input | 1 | Link write flips when the branch is taken |
| bi_scalar | input | 1 | Condition field is scalar |
| ctr_in | input | 16 | Count value at launch |
| cia | input | 32 | Current instruction address |
| taken | output | 1 | Branch decision |
| ctr_out | output | 16 | Updated count |
| vl_out | output | 4 | Resulting vector length |
| vl_changed | output | 1 | Truncation happened |
| lr_we | output | 1 | Link register write enable, valid with done |
| lr_val | output | 32 | Return address |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default parameters: eight elements, sixteen fields and a 16-bit count. With sixteen fields, a base index near the top wraps to field 0 within one run. The 16-bit count makes the wrap from zero to 0xFFFF visible on `ctr_out`. Eight elements leave room for the 0b110010 mask case, where skipped, substituted and inclusive truncation give lengths 2, 4 and 5. Cycle counts taken at the ports show where each walk stopped.

// File: rtl/vbc_pkg.sv
package vbc_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_STEP = 2'd1,
        S_DONE = 2'd2
    } vbc_state_e;

    typedef struct packed {
        logic all_m;
        logic snz;
        logic sz;
        logic ctr_test;
        logic cti;
        logic vlset;
        logic vsb;
        logic vli;
        logic lk;
        logic lru;
        logic scalar;
    } vbc_mode_t;

endpackage

// File: rtl/vbc_field_pick.sv
module vbc_field_pick #(
    parameter int NFIELD = 16,
    parameter int STEP_W = 3,
    localparam int FIDX_W = $clog2(NFIELD)
) (
    input  logic [NFIELD*4-1:0] fields,
    input  logic [FIDX_W-1:0]   base_idx,
    input  logic [1:0]          bit_sel,
    input  logic [STEP_W-1:0]   step,
    input  logic                hold,
    output logic                bit_o
);
    logic [NFIELD-1:0] column;
    logic [STEP_W-1:0] ofs;
    logic [FIDX_W-1:0] idx;

    // One candidate bit per field, all at the same position
    for (genvar g = 0; g < NFIELD; g++) begin : g_col
        assign column[g] = fields[4*g + int'(bit_sel)];
    end

    assign ofs   = hold ? '0 : step;
    assign idx   = base_idx + FIDX_W'(ofs);
    assign bit_o = column[idx];
endmodule

// File: rtl/vbc_elem_test.sv
module vbc_elem_test
    import vbc_pkg::*;
(
    input  logic      cr_bit,
    input  logic      masked,
    input  logic      ctr_nz,
    input  logic [3:0] bo,
    input  vbc_mode_t mode,
    output logic      skip,
    output logic      dec,
    output logic      pass
);
    logic testbit;
    logic cond;
    logic ctr_ok;

    always_comb begin
        testbit = masked ? mode.snz : cr_bit;
        cond    = bo[0] | (testbit == bo[1]);
        ctr_ok  = bo[2] | (ctr_nz ^ bo[3]);
        pass    = cond & ctr_ok;
        skip    = masked & ~mode.sz;
        if (skip)
            dec = ~bo[2] & mode.ctr_test & ~mode.cti;
        else
            dec = ~bo[2] & ~(mode.ctr_test & (cond ^ mode.cti));
    end
endmodule

// File: rtl/vbc_eval.sv
module vbc_eval
    import vbc_pkg::*;
#(
    parameter int MAX_VL = 8,
    parameter int NFIELD = 16,
    parameter int CTR_W  = 16,
    parameter int ADDR_W = 32,
    localparam int VL_W   = $clog2(MAX_VL + 1),
    localparam int STEP_W = $clog2(MAX_VL),
    localparam int FIDX_W = $clog2(NFIELD),
    localparam int BI_W   = FIDX_W + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [VL_W-1:0]     vl_in,
    input  logic [MAX_VL-1:0]   pmask,
    input  logic [NFIELD*4-1:0] cr_fields,
    input  logic [3:0]          bo,
    input  logic [BI_W-1:0]     bi,
    input  logic                all_mode,
    input  logic                snz,
    input  logic                sz,
    input  logic                ctr_test,
    input  logic                cti,
    input  logic                vlset,
    input  logic                vsb,
    input  logic                vli,
    input  logic                lk,
    input  logic                lru,
    input  logic                bi_scalar,
    input  logic [CTR_W-1:0]    ctr_in,
    input  logic [ADDR_W-1:0]   cia,
    output logic                taken,
    output logic [CTR_W-1:0]    ctr_out,
    output logic [VL_W-1:0]     vl_out,
    output logic                vl_changed,
    output logic                lr_we,
    output logic [ADDR_W-1:0]   lr_val,
    output logic                done
);
    vbc_state_e state_q, state_d;

    logic [STEP_W-1:0]   step_q;
    logic [VL_W-1:0]     vl_q;
    logic [MAX_VL-1:0]   mask_q;
    logic [NFIELD*4-1:0] fields_q;
    logic [3:0]          bo_q;
    logic [BI_W-1:0]     bi_q;
    vbc_mode_t           mode_q;
    logic [ADDR_W-1:0]   cia_q;
    logic [CTR_W-1:0]    ctr_q;
    logic                acc_q;
    logic [VL_W-1:0]     keep_q;
    logic [VL_W-1:0]     vlnew_q;
    logic                trunc_q;

    logic                cr_bit;
    logic                el_skip, el_dec, el_pass;
    logic [VL_W-1:0]     step_p1;
    logic                last_el, trunc_hit, fin;

    vbc_field_pick #(.NFIELD(NFIELD), .STEP_W(STEP_W)) u_pick (
        .fields   (fields_q),
        .base_idx (bi_q[BI_W-1:2]),
        .bit_sel  (bi_q[1:0]),
        .step     (step_q),
        .hold     (mode_q.scalar),
        .bit_o    (cr_bit)
    );

    vbc_elem_test u_elem (
        .cr_bit (cr_bit),
        .masked (~mask_q[step_q]),
        .ctr_nz (|ctr_q),
        .bo     (bo_q),
        .mode   (mode_q),
        .skip   (el_skip),
        .dec    (el_dec),
        .pass   (el_pass)
    );

    // Stop decision for the element under test
    always_comb begin
        step_p1   = VL_W'(step_q) + VL_W'(1);
        last_el   = (step_p1 == vl_q);
        trunc_hit = ~el_skip & mode_q.vlset & (mode_q.vsb == el_pass);
        fin       = last_el |
                    (~el_skip & (trunc_hit | (mode_q.all_m != el_pass) | mode_q.scalar));
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = (vl_in == '0) ? S_DONE : S_STEP;
            S_STEP: if (fin)   state_d = S_DONE;
            S_DONE:            state_d = S_IDLE;
            default:           state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q   <= '0;
            vl_q     <= '0;
            mask_q   <= '0;
            fields_q <= '0;
            bo_q     <= '0;
            bi_q     <= '0;
            mode_q   <= '0;
            cia_q    <= '0;
            ctr_q    <= '0;
            acc_q    <= 1'b0;
            keep_q   <= '0;
            vlnew_q  <= '0;
            trunc_q  <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    step_q   <= '0;
                    vl_q     <= vl_in;
                    mask_q   <= pmask;
                    fields_q <= cr_fields;
                    bo_q     <= bo;
                    bi_q     <= bi;
                    mode_q   <= '{all_m: all_mode, snz: snz, sz: sz, ctr_test: ctr_test,
                                  cti: cti, vlset: vlset, vsb: vsb, vli: vli, lk: lk,
                                  lru: lru, scalar: bi_scalar};
                    cia_q    <= cia;
                    ctr_q    <= ctr_in;
                    acc_q    <= all_mode;
                    keep_q   <= '0;
                    vlnew_q  <= vl_in;
                    trunc_q  <= 1'b0;
                end
                S_STEP: begin
                    step_q <= step_q + STEP_W'(1);
                    if (el_dec) ctr_q <= ctr_q - CTR_W'(1);
                    if (!el_skip) begin
                        acc_q  <= mode_q.all_m ? (acc_q & el_pass) : (acc_q | el_pass);
                        keep_q <= step_p1;
                        if (trunc_hit) begin
                            vlnew_q <= mode_q.vli ? step_p1 : keep_q;
                            trunc_q <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        done       = (state_q == S_DONE);
        taken      = acc_q;
        ctr_out    = ctr_q;
        vl_out     = vlnew_q;
        vl_changed = trunc_q;
        lr_we      = done & (mode_q.lk ^ (mode_q.lru & acc_q));
        lr_val     = cia_q + ADDR_W'(8);
    end

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r12_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && start) |=> ($stable(cia_q) && $stable(vl_q)));

    a_r8_ctr_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STEP) |=> (ctr_q == $past(ctr_q) || ctr_q == ($past(ctr_q) - CTR_W'(1))));

    a_r5_empty_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start && vl_in == '0) |=>
            (done && taken == $past(all_mode) && ctr_out == $past(ctr_in)));

    a_r7_skip_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STEP && el_skip) |=> ($stable(acc_q) && $stable(keep_q) && $stable(trunc_q)));

    a_r4_all_first_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STEP && !el_skip && mode_q.all_m && !el_pass) |=> (done && !taken));

    a_r9_no_trunc_keeps_vl: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mode_q.vlset) |-> (!vl_changed && vl_out == vl_q));

    a_r9_trunc_not_longer: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (vl_out <= vl_q));

    a_r11_no_link_request: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mode_q.lk && !mode_q.lru) |-> !lr_we);
endmodule

// File: tb/vbc_eval_tb.sv
`timescale 1ns/1ps
module vbc_eval_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  vl_in = '0;
    logic [7:0]  pmask = '0;
    logic [63:0] cr_fields;
    logic [3:0]  bo = '0;
    logic [5:0]  bi = '0;
    logic [10:0] mbits = '0;
    logic [15:0] ctr_in = '0;
    logic [31:0] cia = '0;
    logic        taken, vl_changed, lr_we, done;
    logic [15:0] ctr_out;
    logic [3:0]  vl_out;
    logic [31:0] lr_val;

    int n_chk = 0;
    int n_fail = 0;
    int tick = 0;

    always #4 clk = ~clk;

    vbc_eval u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in), .pmask(pmask),
        .cr_fields(cr_fields), .bo(bo), .bi(bi),
        .all_mode(mbits[10]), .snz(mbits[9]), .sz(mbits[8]), .ctr_test(mbits[7]),
        .cti(mbits[6]), .vlset(mbits[5]), .vsb(mbits[4]), .vli(mbits[3]),
        .lk(mbits[2]), .lru(mbits[1]), .bi_scalar(mbits[0]),
        .ctr_in(ctr_in), .cia(cia), .taken(taken), .ctr_out(ctr_out), .vl_out(vl_out),
        .vl_changed(vl_changed), .lr_we(lr_we), .lr_val(lr_val), .done(done)
    );

    // Field f holds the value f
    always_comb
        for (int f = 0; f < 16; f++) cr_fields[4*f +: 4] = 4'(f);

    typedef struct packed {
        logic [3:0]  vl;
        logic [7:0]  mask;
        logic [3:0]  bo;
        logic [5:0]  bi;
        logic [10:0] m;    // all,snz,sz,ctr_test,cti,vlset,vsb,vli,lk,lru,scalar
        logic [15:0] ctr;
        logic        t;
        logic [15:0] ectr;
        logic [3:0]  evl;
        logic        evc;
        logic        elr;
        logic [3:0]  ecyc;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VT [NV] = '{
        '{4'd8, 8'hFF, 4'b0110, 6'd0,  11'b00000000000, 16'd10, 1'b1, 16'd10,   4'd8, 1'b0, 1'b0, 4'd2},
        '{4'd8, 8'hFF, 4'b0000, 6'd3,  11'b10000000110, 16'd20, 1'b1, 16'd12,   4'd8, 1'b0, 1'b0, 4'd8},
        '{4'd8, 8'hFF, 4'b0000, 6'd19, 11'b10000000100, 16'd5,  1'b0, 16'd0,    4'd8, 1'b0, 1'b1, 4'd5},
        '{4'd6, 8'h32, 4'b0110, 6'd0,  11'b10000100000, 16'd7,  1'b0, 16'd7,    4'd2, 1'b1, 1'b0, 4'd5},
        '{4'd6, 8'h32, 4'b0110, 6'd0,  11'b11100100000, 16'd7,  1'b0, 16'd7,    4'd4, 1'b1, 1'b0, 4'd5},
        '{4'd6, 8'h32, 4'b0110, 6'd0,  11'b10000101000, 16'd7,  1'b0, 16'd7,    4'd5, 1'b1, 1'b0, 4'd5},
        '{4'd4, 8'h05, 4'b0010, 6'd0,  11'b00010000010, 16'd10, 1'b0, 16'd6,    4'd4, 1'b0, 1'b0, 4'd4},
        '{4'd4, 8'h05, 4'b0010, 6'd0,  11'b00011000010, 16'd10, 1'b0, 16'd10,   4'd4, 1'b0, 1'b0, 4'd4},
        '{4'd8, 8'h0C, 4'b0010, 6'd13, 11'b10000000101, 16'd4,  1'b1, 16'd3,    4'd8, 1'b0, 1'b1, 4'd3},
        '{4'd0, 8'hFF, 4'b0110, 6'd0,  11'b00000000000, 16'd5,  1'b0, 16'd5,    4'd0, 1'b0, 1'b0, 4'd0},
        '{4'd0, 8'hFF, 4'b0110, 6'd0,  11'b10000000100, 16'd5,  1'b1, 16'd5,    4'd0, 1'b0, 1'b1, 4'd0},
        '{4'd8, 8'hFF, 4'b0110, 6'd0,  11'b00000111010, 16'd5,  1'b1, 16'd5,    4'd2, 1'b1, 1'b1, 4'd2},
        '{4'd3, 8'hFF, 4'b0101, 6'd0,  11'b10000000000, 16'd9,  1'b1, 16'd9,    4'd3, 1'b0, 1'b0, 4'd3},
        '{4'd8, 8'hFF, 4'b1001, 6'd0,  11'b00000000000, 16'd2,  1'b1, 16'hFFFF, 4'd8, 1'b0, 1'b0, 4'd3},
        '{4'd4, 8'hFF, 4'b0110, 6'd57, 11'b10000000000, 16'd1,  1'b0, 16'd1,    4'd4, 1'b0, 1'b0, 4'd3}
    };
    localparam string TAG [NV] = '{
        "R2 R4 or-exit", "R4 all-pass", "R2 R8 all-fail", "R9 R7 skip-trunc", "R9 R6 snz-trunc",
        "R9 vli-trunc", "R7 R8 skip-dec", "R8 cti", "R10 scalar", "R5 empty-or",
        "R5 empty-and", "R9 R11 vsb-pass", "R2 unconditional", "R2 R8 ctr-sense", "R3 field-wrap"};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic launch(input vec_t v, input logic [31:0] addr);
        @(negedge clk);
        vl_in = v.vl; pmask = v.mask; bo = v.bo; bi = v.bi; mbits = v.m;
        ctr_in = v.ctr; cia = addr; start = 1'b1;
        @(posedge clk);
    endtask

    task automatic wait_done(output int cyc);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 40) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
    endtask

    always @(posedge clk) begin
        tick++;
        if (tick == 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R12 watchdog actual=%0d expected<150000", tick);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int cyc;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 done", 32'(done), 0);
        chk("R1 taken", 32'(taken), 0);
        chk("R1 lr_we", 32'(lr_we), 0);
        chk("R1 vl_changed", 32'(vl_changed), 0);
        chk("R1 ctr_out", 32'(ctr_out), 0);
        chk("R1 vl_out", 32'(vl_out), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [31:0] addr;
            addr = 32'h1000 + 32'(i) * 32'h40;
            launch(VT[i], addr);
            wait_done(cyc);
            chk({TAG[i], " taken"}, 32'(taken), 32'(VT[i].t));
            chk({TAG[i], " ctr"}, 32'(ctr_out), 32'(VT[i].ectr));
            chk({TAG[i], " vl"}, 32'(vl_out), 32'(VT[i].evl));
            chk({TAG[i], " vl_changed"}, 32'(vl_changed), 32'(VT[i].evc));
            chk({TAG[i], " R11 lr_we"}, 32'(lr_we), 32'(VT[i].elr));
            chk({TAG[i], " R11 lr_val"}, lr_val, addr + 32'd8);
            chk({TAG[i], " R12 cycles"}, 32'(cyc), 32'(VT[i].ecyc));
            @(negedge clk);
            chk({TAG[i], " R12 done one cycle"}, 32'(done), 0);
        end

        // R12: start while busy is ignored
        launch(VT[1], 32'h2000);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        vl_in = 4'd0; cia = 32'h3000; ctr_in = 16'd99; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        chk("R12 busy start ctr", 32'(ctr_out), 32'd12);
        chk("R12 busy start vl", 32'(vl_out), 32'd8);
        chk("R12 busy start lr_val", lr_val, 32'h2008);
        @(negedge clk);
        chk("R12 idle after busy", 32'(done), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule